// File: doc/BRIEF.md
# Two-Wire Register Access Master

This block is a bit-level master for a two-wire serial bus. It performs one register transfer per command on a slave whose registers are selected by an 8-bit index. A command gives a 7-bit device address, the register index, a write byte and a read/write flag, and a one-cycle start strobe launches it. The block then drives the clock and data lines as open-drain outputs, where a high output means "pull the line low". It samples the data line back to see acknowledges and read bits. When the transaction ends it raises a one-cycle done pulse, with a no-acknowledge error flag and the read byte.

Every bus symbol is either a start, a data bit or a stop. Each symbol is built from four equal steps, and each step lasts a programmable number of system clocks, never fewer than four. A write sends start, the device address with a zero direction bit, the index and the data, and then a stop. A read sends the address and index in the same way. It then makes a repeated start, sends the address with the direction bit set, clocks in one byte, and leaves the ninth clock unacknowledged before the stop. If any acknowledge is missing, the transfer is cut short at once and no stop is sent.

Top module: `twr_reg_master`

## Requirements
- R1: Out of reset and whenever busy is low, both line drives (scl_oe, sda_oe) are off. After reset, done, nack_err and rdata are zero.
- R2: A start condition drops SDA while SCL is high, and one step later drops SCL. A start from idle begins with SCL high. A repeated start first releases SDA while SCL is low, then raises SCL.
- R3: Bytes go out most significant bit first. Each bit takes four steps: SCL low, high, high, low. SDA holds the bit value for all four steps, so it only changes while SCL is low.
- R4: A write frame is: start, {dev,0}, index, data, then stop. Each byte is followed by an acknowledge slot with SDA released. The stop is SDA low with SCL low, then SCL high, then SDA high for two steps.
- R5: A read frame is: start, {dev,0}, index, repeated start, {dev,1}, eight received bits, a ninth slot with SDA released, then stop. Each received bit is sampled at the end of the first SCL-high step, MSB first.
- R6: The acknowledge is sampled at the end of the first SCL-high step of the slot. A high level there ends the transfer on that edge: done pulses with nack_err = 1, both lines are released, and no stop is sent.
- R7: done is a single-cycle pulse in the first cycle in which the lines are back at idle. busy is low in that same cycle.
- R8: rdata changes only when done pulses at the end of a completed read, and holds otherwise. nack_err is valid with done and holds until the next accepted command clears it.
- R9: A cmd_start that arrives while busy is high has no effect on the transfer in progress.
- R10: One step lasts quarter_div system clocks. Values below 4 are treated as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| quarter_div | input | DIV_W | System clocks per bus step (minimum 4) |
| cmd_start | input | 1 | One-cycle command strobe, taken when idle |
| cmd_read | input | 1 | 1 = register read, 0 = register write |
| cmd_dev | input | 7 | Slave device address |
| cmd_reg | input | 8 | Register index |
| cmd_wdata | input | 8 | Byte to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| nack_err | output | 1 | Transaction ended on a missing acknowledge |
| rdata | output | 8 | Last byte read |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
Some behaviours are checked by assertions on every cycle. These are the idle release of both lines, the single-cycle done pulse with busy low, and the stability of rdata outside done. They also cover the fact that an aborted transfer ends with both lines already released, so no stop edge can appear, and that a command is accepted only when the block is idle. The exact waveform cannot be seen by a property: the order of symbols, MSB-first bit values, step lengths with the divider clamp, and which acknowledge slot ends a transfer. The bench checks these against a step-by-step model of the frame and a modelled slave that acknowledges, withholds acknowledge or returns data bytes.

// File: rtl/twr_pkg.sv
package twr_pkg;
  localparam int BYTE_W  = 8;
  localparam int DEV_W   = 7;
  localparam int QTR_MIN = 4;
  localparam int BIT_W   = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    SEG_IDLE,
    SEG_START1,
    SEG_ADDRW,
    SEG_REG,
    SEG_WDATA,
    SEG_START2,
    SEG_ADDRR,
    SEG_RDATA,
    SEG_STOP
  } seg_e;

  function automatic logic is_byte(seg_e s);
    return (s == SEG_ADDRW) || (s == SEG_REG) || (s == SEG_WDATA) ||
           (s == SEG_ADDRR) || (s == SEG_RDATA);
  endfunction

  function automatic seg_e seg_after(seg_e s, logic rd);
    case (s)
      SEG_START1: return SEG_ADDRW;
      SEG_ADDRW:  return SEG_REG;
      SEG_REG:    return rd ? SEG_START2 : SEG_WDATA;
      SEG_WDATA:  return SEG_STOP;
      SEG_START2: return SEG_ADDRR;
      SEG_ADDRR:  return SEG_RDATA;
      SEG_RDATA:  return SEG_STOP;
      default:    return SEG_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/twr_step_timer.sv
module twr_step_timer
  import twr_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d, last_cnt;

  // R10: clamp the step length to the minimum
  always_comb begin
    if (div < DIV_W'(QTR_MIN)) last_cnt = DIV_W'(QTR_MIN - 1);
    else                       last_cnt = div - DIV_W'(1);
    tick  = run && (cnt_q == last_cnt);
    cnt_d = (!run || tick) ? '0 : cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/twr_line_encode.sv
module twr_line_encode
  import twr_pkg::*;
(
  input  seg_e       seg,
  input  logic [1:0] qtr,
  input  logic       tx_bit,
  output logic       scl_rel,
  output logic       sda_rel
);
  always_comb begin
    scl_rel = 1'b1;
    sda_rel = 1'b1;
    case (seg)
      SEG_IDLE: begin
        scl_rel = 1'b1;
        sda_rel = 1'b1;
      end
      SEG_START1, SEG_START2: begin
        case (qtr)
          2'd0:    begin scl_rel = (seg == SEG_START1); sda_rel = 1'b1; end
          2'd1:    begin scl_rel = 1'b1; sda_rel = 1'b1; end
          2'd2:    begin scl_rel = 1'b1; sda_rel = 1'b0; end
          default: begin scl_rel = 1'b0; sda_rel = 1'b0; end
        endcase
      end
      SEG_STOP: begin
        case (qtr)
          2'd0:    begin scl_rel = 1'b0; sda_rel = 1'b0; end
          2'd1:    begin scl_rel = 1'b1; sda_rel = 1'b0; end
          default: begin scl_rel = 1'b1; sda_rel = 1'b1; end
        endcase
      end
      default: begin
        scl_rel = (qtr == 2'd1) || (qtr == 2'd2);
        sda_rel = tx_bit;
      end
    endcase
  end
endmodule

// File: rtl/twr_sequencer.sv
module twr_sequencer
  import twr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cmd_start,
  input  logic              cmd_read,
  input  logic [DEV_W-1:0]  cmd_dev,
  input  logic [BYTE_W-1:0] cmd_reg,
  input  logic [BYTE_W-1:0] cmd_wdata,
  input  logic              sda_in,
  output seg_e              seg,
  output logic [1:0]        qtr,
  output logic              tx_bit,
  output logic              done,
  output logic              nack_err,
  output logic [BYTE_W-1:0] rdata
);
  seg_e              seg_q, seg_d;
  logic [1:0]        qtr_q, qtr_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              rd_q, rd_d;
  logic [DEV_W-1:0]  dev_q, dev_d;
  logic [BYTE_W-1:0] reg_q, reg_d, wd_q, wd_d, sh_q, sh_d, rdat_q, rdat_d;
  logic [BYTE_W-1:0] tx_byte, tx_shift;
  logic              done_q, done_d, err_q, err_d, abort;

  // byte being sent in the current segment; all ones leaves SDA released
  always_comb begin
    case (seg_q)
      SEG_ADDRW: tx_byte = {dev_q, 1'b0};
      SEG_REG:   tx_byte = reg_q;
      SEG_WDATA: tx_byte = wd_q;
      SEG_ADDRR: tx_byte = {dev_q, 1'b1};
      default:   tx_byte = '1;
    endcase
    tx_shift = tx_byte << bit_q;
    tx_bit   = (bit_q < BIT_W'(BYTE_W)) ? tx_shift[BYTE_W-1] : 1'b1;
  end

  always_comb begin
    seg_d  = seg_q;
    qtr_d  = qtr_q;
    bit_d  = bit_q;
    rd_d   = rd_q;
    dev_d  = dev_q;
    reg_d  = reg_q;
    wd_d   = wd_q;
    sh_d   = sh_q;
    rdat_d = rdat_q;
    err_d  = err_q;
    done_d = 1'b0;
    abort  = 1'b0;
    if (seg_q == SEG_IDLE) begin
      // R9: commands are only taken here
      if (cmd_start) begin
        rd_d  = cmd_read;
        dev_d = cmd_dev;
        reg_d = cmd_reg;
        wd_d  = cmd_wdata;
        err_d = 1'b0;
        seg_d = SEG_START1;
        qtr_d = 2'd0;
        bit_d = '0;
      end
    end else if (tick) begin
      if (is_byte(seg_q) && (qtr_q == 2'd1)) begin
        if (bit_q == BIT_W'(BYTE_W)) begin
          if ((seg_q != SEG_RDATA) && sda_in) abort = 1'b1;
        end else if (seg_q == SEG_RDATA) begin
          sh_d = {sh_q[BYTE_W-2:0], sda_in};
        end
      end
      if (abort) begin
        seg_d  = SEG_IDLE;
        done_d = 1'b1;
        err_d  = 1'b1;
      end else if (qtr_q != 2'd3) begin
        qtr_d = qtr_q + 2'd1;
      end else begin
        qtr_d = 2'd0;
        if (is_byte(seg_q) && (bit_q != BIT_W'(BYTE_W))) begin
          bit_d = bit_q + BIT_W'(1);
        end else begin
          bit_d = '0;
          seg_d = seg_after(seg_q, rd_q);
          if (seg_q == SEG_STOP) begin
            done_d = 1'b1;
            if (rd_q) rdat_d = sh_q;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q  <= SEG_IDLE;
      qtr_q  <= '0;
      bit_q  <= '0;
      rd_q   <= 1'b0;
      dev_q  <= '0;
      reg_q  <= '0;
      wd_q   <= '0;
      sh_q   <= '0;
      rdat_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      seg_q  <= seg_d;
      qtr_q  <= qtr_d;
      bit_q  <= bit_d;
      rd_q   <= rd_d;
      dev_q  <= dev_d;
      reg_q  <= reg_d;
      wd_q   <= wd_d;
      sh_q   <= sh_d;
      rdat_q <= rdat_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign seg      = seg_q;
  assign qtr      = qtr_q;
  assign done     = done_q;
  assign nack_err = err_q;
  assign rdata    = rdat_q;
endmodule

// File: rtl/twr_reg_master.sv
module twr_reg_master
  import twr_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  quarter_div,
  input  logic              cmd_start,
  input  logic              cmd_read,
  input  logic [DEV_W-1:0]  cmd_dev,
  input  logic [BYTE_W-1:0] cmd_reg,
  input  logic [BYTE_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              done,
  output logic              nack_err,
  output logic [BYTE_W-1:0] rdata,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              sda_in
);
  seg_e       seg;
  logic [1:0] qtr;
  logic       tx_bit, tick, scl_rel, sda_rel;

  assign busy = (seg != SEG_IDLE);

  twr_step_timer #(.DIV_W(DIV_W)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .div  (quarter_div),
    .tick (tick)
  );

  twr_sequencer u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .cmd_start(cmd_start),
    .cmd_read (cmd_read),
    .cmd_dev  (cmd_dev),
    .cmd_reg  (cmd_reg),
    .cmd_wdata(cmd_wdata),
    .sda_in   (sda_in),
    .seg      (seg),
    .qtr      (qtr),
    .tx_bit   (tx_bit),
    .done     (done),
    .nack_err (nack_err),
    .rdata    (rdata)
  );

  twr_line_encode u_enc (
    .seg    (seg),
    .qtr    (qtr),
    .tx_bit (tx_bit),
    .scl_rel(scl_rel),
    .sda_rel(sda_rel)
  );

  assign scl_oe = ~scl_rel;
  assign sda_oe = ~sda_rel;
endmodule

// File: rtl/twr_reg_master_chk.sv
module twr_reg_master_chk
  import twr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_start,
  input logic              busy,
  input logic              done,
  input logic              nack_err,
  input logic [BYTE_W-1:0] rdata,
  input logic              scl_oe,
  input logic              sda_oe
);
  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  nack_no_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && nack_err) |-> ($past(!sda_oe) && $past(!scl_oe)));

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata) |-> done);

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(nack_err));

  // R9
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_start) |=> (busy && !nack_err));
endmodule

bind twr_reg_master twr_reg_master_chk u_twr_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_start(cmd_start),
  .busy     (busy),
  .done     (done),
  .nack_err (nack_err),
  .rdata    (rdata),
  .scl_oe   (scl_oe),
  .sda_oe   (sda_oe)
);

// File: tb/twr_reg_master_bench.sv
module twr_reg_master_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] quarter_div;
  logic       cmd_start, cmd_read;
  logic [6:0] cmd_dev;
  logic [7:0] cmd_reg, cmd_wdata;
  logic       busy, done, nack_err, scl_oe, sda_oe, sda_in;
  logic [7:0] rdata;
  logic       slave_pull;

  int total = 0;
  int bad   = 0;
  logic [7:0] exp_rdata;

  bit q_scl[$];
  bit q_sda[$];
  bit q_pull[$];

  always #10 clk = ~clk;

  assign sda_in = ~sda_oe & ~slave_pull;

  twr_reg_master u_twr_reg_master (
    .clk(clk), .rst_n(rst_n), .quarter_div(quarter_div),
    .cmd_start(cmd_start), .cmd_read(cmd_read), .cmd_dev(cmd_dev),
    .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .nack_err(nack_err), .rdata(rdata), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .sda_in(sda_in)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // model: one queue entry per bus step {scl level, master sda level, slave pull}
  task automatic push(input bit s, input bit d, input bit p);
    q_scl.push_back(s);
    q_sda.push_back(d);
    q_pull.push_back(p);
  endtask

  task automatic push_start(input bit from_idle);
    push(from_idle, 1, 0); push(1, 1, 0); push(1, 0, 0); push(0, 0, 0);
  endtask

  task automatic push_bit(input bit d, input bit p);
    push(0, d, p); push(1, d, p); push(1, d, p); push(0, d, p);
  endtask

  task automatic push_wbyte(input logic [7:0] v, input bit ack, output bit aborted);
    for (int i = 7; i >= 0; i--) push_bit(v[i], 0);
    if (ack) begin
      push_bit(1, 1);
      aborted = 0;
    end else begin
      push(0, 1, 0); push(1, 1, 0);
      aborted = 1;
    end
  endtask

  task automatic push_rbyte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) push_bit(1, ~v[i]);
    push_bit(1, 0);
  endtask

  task automatic push_stop();
    push(0, 0, 0); push(1, 0, 0); push(1, 1, 0); push(1, 1, 0);
  endtask

  // nack_at: 0 = first address, 1 = index, 2 = data or read address, -1 = none
  task automatic run_cmd(input bit rd, input logic [6:0] dev, input logic [7:0] rg,
                         input logic [7:0] wd, input logic [7:0] sv, input int nack_at,
                         input int div, input bit inject, input string tag);
    bit ab;
    bit exp_err;
    logic [7:0] new_rdata;
    int d, n;
    q_scl.delete(); q_sda.delete(); q_pull.delete();
    push_start(1);
    push_wbyte({dev, 1'b0}, nack_at != 0, ab);
    if (!ab) push_wbyte(rg, nack_at != 1, ab);
    if (!ab) begin
      if (!rd) begin
        push_wbyte(wd, nack_at != 2, ab);
        if (!ab) push_stop();
      end else begin
        push_start(0);
        push_wbyte({dev, 1'b1}, nack_at != 2, ab);
        if (!ab) begin
          push_rbyte(sv);
          push_stop();
        end
      end
    end
    exp_err   = ab;
    new_rdata = (!ab && rd) ? sv : exp_rdata;
    d = (div < 4) ? 4 : div;   // R10
    n = q_scl.size() * d;

    @(negedge clk);
    quarter_div = 8'(div);
    cmd_read = rd; cmd_dev = dev; cmd_reg = rg; cmd_wdata = wd;
    cmd_start = 1'b1;
    for (int j = 0; j <= n + 1; j++) begin
      @(negedge clk);
      cmd_start = 1'b0;
      if (inject && j == 40) begin
        // R9: strobe with different fields while busy
        cmd_start = 1'b1; cmd_read = ~rd; cmd_dev = 7'h11; cmd_reg = 8'hEE;
      end
      if (j < n) begin
        int k;
        k = j / d;
        slave_pull = q_pull[k];
        // R2 R3 R4 R5 R10: step-by-step line levels and step length
        chk((scl_oe == !q_scl[k]) && (sda_oe == !q_sda[k]) && busy && !done &&
            !nack_err && (rdata == exp_rdata), tag, "bus step",
            {rdata, 3'b0, scl_oe, sda_oe, busy, done, nack_err},
            {exp_rdata, 3'b0, !q_scl[k], !q_sda[k], 3'b100});
      end else if (j == n) begin
        slave_pull = 1'b0;
        chk(done && !busy, "R7", "done pulse at end", {done, busy}, 2'b10);
        chk(!scl_oe && !sda_oe, "R6", "lines released at end", {scl_oe, sda_oe}, 0);
        chk(nack_err == exp_err, "R6", "error flag", nack_err, exp_err);
        chk(rdata == new_rdata, "R8", "read data at done", rdata, new_rdata);
      end else begin
        chk(!done, "R7", "done one cycle", done, 0);
        chk(nack_err == exp_err && rdata == new_rdata, "R8", "flags held",
            {nack_err, rdata}, {exp_err, new_rdata});
      end
    end
    exp_rdata = new_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; quarter_div = 8'd4; cmd_start = 1'b0; cmd_read = 1'b0;
    cmd_dev = '0; cmd_reg = '0; cmd_wdata = '0; slave_pull = 1'b0;
    exp_rdata = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!scl_oe && !sda_oe && !busy && !done && !nack_err && rdata == 8'h00, "R1",
        "reset state", {scl_oe, sda_oe, busy, done, nack_err, rdata}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy, "R1", "idle after reset", {scl_oe, sda_oe, busy}, 0);

    run_cmd(0, 7'h50, 8'h3C, 8'hA5, 8'h00, -1, 4, 0, "R4");
    run_cmd(1, 7'h2B, 8'h81, 8'h00, 8'h96, -1, 5, 0, "R5");
    run_cmd(0, 7'h13, 8'h07, 8'h5A, 8'h00, 0, 4, 0, "R6");
    repeat (5) @(negedge clk);
    chk(nack_err && !busy && !scl_oe && !sda_oe, "R8", "error held while idle",
        {nack_err, busy, scl_oe, sda_oe}, 4'b1000);
    run_cmd(1, 7'h44, 8'h20, 8'h00, 8'hC3, 2, 4, 0, "R6");
    run_cmd(0, 7'h7F, 8'hFF, 8'h01, 8'h00, 2, 4, 0, "R6");
    run_cmd(1, 7'h01, 8'h10, 8'h00, 8'h77, 1, 4, 0, "R6");
    run_cmd(0, 7'h22, 8'h55, 8'hC0, 8'h00, -1, 2, 0, "R10");
    run_cmd(1, 7'h36, 8'h42, 8'h00, 8'h3F, -1, 4, 1, "R9");
    run_cmd(1, 7'h00, 8'h00, 8'h00, 8'h00, -1, 6, 0, "R5");
    run_cmd(1, 7'h7F, 8'hFE, 8'h00, 8'hFF, -1, 4, 0, "R5");
    run_cmd(0, 7'h5D, 8'h01, 8'h81, 8'h00, -1, 7, 0, "R3");
    repeat (4) @(negedge clk);
    chk(!busy && !done && !scl_oe && !sda_oe, "R1", "final idle",
        {busy, done, scl_oe, sda_oe}, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule